// File: doc/BRIEF.md
# Bridge Error Capture and Interrupt Controller

This block sits beside a bus bridge and turns its one-cycle error pulses into sticky status. The pulses come from both sides of the bridge. On the external bus they are master abort, target abort, a detected parity error, and single-bit and multi-bit ECC errors. On the internal bus they are a memory-controller ECC error, an internal byte parity error, and an internal master abort caused by bad addressing. Each captured cause sets its own status bit. When the cause's interrupt mask bit is clear, it also sets the matching bit of a second, interrupt-status register. Any unmasked pending interrupt-status bit drives a registered interrupt line toward the local processor.

Data errors are classified by bus mode. In the three lower bus modes, data checking uses parity. In the highest mode it uses ECC. A single-bit ECC error is corrected silently when correction is enabled, and is treated as uncorrectable otherwise. Every uncorrectable or abort-class event produces a one-cycle abort strobe that sends the bridge state machines back to idle. Software reads both registers through a small port and clears bits by writing ones.

Top module: `bridge_err_ctrl`

## Requirements
- R1: One cycle after an error pulse, the status register holds a 1 at that cause's bit. The bit positions are: 0 external master abort, 1 external target abort, 2 uncorrectable data error, 3 corrected single-bit error, 4 memory-controller ECC error, 5 internal byte parity error, 6 internal master abort.
- R2: The same event sets the same bit position in the interrupt-status register only if `intMask` at that position is 0. A 1 in `intMask` blocks the setting.
- R3: `irq` is a register loaded each cycle with the OR of (interrupt status AND NOT `intMask`). It rises one cycle after an unmasked bit becomes pending and falls one cycle after the last such bit is cleared or masked.
- R4: Bits are sticky and are cleared only by a write. `regSel` 0 selects status and 1 selects interrupt status. A write with `regWrEn` high clears each bit where `regWrData` has a 1 and leaves bits with a 0 untouched.
- R5: When an event and a clearing write hit the same bit in the same cycle, the bit stays set.
- R6: `abortReq` is high in the cycle after any cycle that carried an abort-class event. Every cause except bit 3 is abort-class. After an isolated event, `abortReq` is high for exactly one cycle.
- R7: With `busMode` 0, 1 or 2, a parity pulse sets bit 2. The single-bit and multi-bit ECC pulses are ignored in these modes.
- R8: With `busMode` 3, a multi-bit ECC pulse sets bit 2, and the parity pulse is ignored.
- R9: With `busMode` 3, a single-bit ECC pulse sets bit 3 without an abort when `eccCorrEn` is 1. When `eccCorrEn` is 0, it sets bit 2 and raises the abort.
- R10: Each internal-bus error sets its own bit (4, 5 or 6) and raises the abort.
- R11: After reset, both registers read zero, and `irq` and `abortReq` are low.
- R12: `regRdData` shows the register picked by `regSel` in the same cycle, with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| masterAbortIn | input | 1 | External master abort pulse |
| targetAbortIn | input | 1 | External target abort pulse |
| parityErrIn | input | 1 | External data parity error pulse |
| sbeIn | input | 1 | External single-bit ECC error pulse |
| mbeIn | input | 1 | External multi-bit ECC error pulse |
| memEccIn | input | 1 | Memory-controller ECC error pulse |
| intParIn | input | 1 | Internal byte parity error pulse |
| intMaIn | input | 1 | Internal master abort pulse |
| busMode | input | 2 | Bus mode, 3 = ECC mode, 0..2 = parity modes |
| eccCorrEn | input | 1 | Single-bit correction enable |
| intMask | input | 7 | Per-cause interrupt mask, 1 = masked |
| regSel | input | 1 | Register select: 0 status, 1 interrupt status |
| regWrEn | input | 1 | Write-one-to-clear strobe |
| regWrData | input | 7 | Bits to clear |
| regRdData | output | 7 | Selected register contents |
| irq | output | 1 | Interrupt to local processor |
| abortReq | output | 1 | One-cycle return-to-idle strobe |

## Verification
The assertions check the following on every cycle:
- the registered interrupt equation;
- that status bits never drop without a clearing write;
- that no interrupt-status bit is newly set while its mask is high;
- that abort-class pulses and set-versus-clear collisions resolve as required;
- that a corrected single-bit error never causes an abort.

The mode classification needs directed bench scenarios. These cover the mode-dependent ignoring of parity and ECC pulses, the correction-enable choice, the reset state and the read port. The random bench also compares both registers, `irq` and `abortReq` against a reference model over long mixes of overlapping events, mask changes and writes.

// File: rtl/berr_pkg.sv
package berr_pkg;
  localparam int NUM_SRC = 7;
  localparam int MODE_W  = 2;
  localparam int SEL_W   = 1;

  localparam int IDX_MA   = 0;
  localparam int IDX_TA   = 1;
  localparam int IDX_UNC  = 2;
  localparam int IDX_COR  = 3;
  localparam int IDX_IMEM = 4;
  localparam int IDX_IPAR = 5;
  localparam int IDX_IMA  = 6;

  localparam logic [MODE_W-1:0] MODE_ECC   = MODE_W'(3);
  localparam logic [SEL_W-1:0]  SEL_STATUS = SEL_W'(0);
  localparam logic [SEL_W-1:0]  SEL_INT    = SEL_W'(1);

  typedef logic [NUM_SRC-1:0] srcVec_t;

  // strobes from control to datapath
  typedef struct packed {
    srcVec_t setEvt;
    logic    fatal;
  } ctlStrobe_t;
endpackage

// File: rtl/berr_sticky_bit.sv
module berr_sticky_bit (
  input  logic clk,
  input  logic rstN,
  input  logic setIn,
  input  logic clrIn,
  output logic q
);
  // set has priority over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) q <= 1'b0;
    else       q <= setIn | (q & ~clrIn);
  end
endmodule

// File: rtl/berr_classify.sv
module berr_classify
  import berr_pkg::*;
(
  input  logic              masterAbortIn,
  input  logic              targetAbortIn,
  input  logic              parityErrIn,
  input  logic              sbeIn,
  input  logic              mbeIn,
  input  logic              memEccIn,
  input  logic              intParIn,
  input  logic              intMaIn,
  input  logic [MODE_W-1:0] busMode,
  input  logic              eccCorrEn,
  output ctlStrobe_t        strobe
);
  localparam srcVec_t FATAL_SET = ~(srcVec_t'(1) << IDX_COR);

  logic    eccMode;
  logic    dataUnc;
  logic    dataCor;
  srcVec_t evt;

  always_comb begin
    eccMode = (busMode == MODE_ECC);
    if (eccMode) begin
      dataUnc = mbeIn | (sbeIn & ~eccCorrEn);
      dataCor = sbeIn & eccCorrEn;
    end else begin
      dataUnc = parityErrIn;
      dataCor = 1'b0;
    end
  end

  always_comb begin
    evt           = '0;
    evt[IDX_MA]   = masterAbortIn;
    evt[IDX_TA]   = targetAbortIn;
    evt[IDX_UNC]  = dataUnc;
    evt[IDX_COR]  = dataCor;
    evt[IDX_IMEM] = memEccIn;
    evt[IDX_IPAR] = intParIn;
    evt[IDX_IMA]  = intMaIn;
  end

  assign strobe.setEvt = evt;
  assign strobe.fatal  = |(evt & FATAL_SET);
endmodule

// File: rtl/berr_regs.sv
module berr_regs
  import berr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  srcVec_t          intMask,
  input  logic [SEL_W-1:0] regSel,
  input  logic             regWrEn,
  input  srcVec_t          regWrData,
  output srcVec_t          statusQ,
  output srcVec_t          intStatQ,
  output srcVec_t          regRdData,
  output logic             irq,
  output logic             abortReq
);
  srcVec_t clrStat;
  srcVec_t clrInt;
  srcVec_t intSet;

  always_comb begin
    clrStat = (regWrEn && regSel == SEL_STATUS) ? regWrData : '0;
    clrInt  = (regWrEn && regSel == SEL_INT)    ? regWrData : '0;
    intSet  = strobe.setEvt & ~intMask;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    berr_sticky_bit u_stat (
      .clk  (clk),
      .rstN (rstN),
      .setIn(strobe.setEvt[i]),
      .clrIn(clrStat[i]),
      .q    (statusQ[i])
    );
    berr_sticky_bit u_int (
      .clk  (clk),
      .rstN (rstN),
      .setIn(intSet[i]),
      .clrIn(clrInt[i]),
      .q    (intStatQ[i])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irq      <= 1'b0;
      abortReq <= 1'b0;
    end else begin
      irq      <= |(intStatQ & ~intMask);
      abortReq <= strobe.fatal;
    end
  end

  assign regRdData = (regSel == SEL_INT) ? intStatQ : statusQ;
endmodule

// File: rtl/bridge_err_ctrl.sv
module bridge_err_ctrl
  import berr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 masterAbortIn,
  input  logic                 targetAbortIn,
  input  logic                 parityErrIn,
  input  logic                 sbeIn,
  input  logic                 mbeIn,
  input  logic                 memEccIn,
  input  logic                 intParIn,
  input  logic                 intMaIn,
  input  logic [MODE_W-1:0]    busMode,
  input  logic                 eccCorrEn,
  input  logic [NUM_SRC-1:0]   intMask,
  input  logic [SEL_W-1:0]     regSel,
  input  logic                 regWrEn,
  input  logic [NUM_SRC-1:0]   regWrData,
  output logic [NUM_SRC-1:0]   regRdData,
  output logic                 irq,
  output logic                 abortReq
);
  ctlStrobe_t strobe;
  srcVec_t    statusQ;
  srcVec_t    intStatQ;

  berr_classify u_ctl (
    .masterAbortIn(masterAbortIn),
    .targetAbortIn(targetAbortIn),
    .parityErrIn  (parityErrIn),
    .sbeIn        (sbeIn),
    .mbeIn        (mbeIn),
    .memEccIn     (memEccIn),
    .intParIn     (intParIn),
    .intMaIn      (intMaIn),
    .busMode      (busMode),
    .eccCorrEn    (eccCorrEn),
    .strobe       (strobe)
  );

  berr_regs u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .intMask  (intMask),
    .regSel   (regSel),
    .regWrEn  (regWrEn),
    .regWrData(regWrData),
    .statusQ  (statusQ),
    .intStatQ (intStatQ),
    .regRdData(regRdData),
    .irq      (irq),
    .abortReq (abortReq)
  );
endmodule

// File: rtl/berr_checker.sv
module berr_checker
  import berr_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               masterAbortIn,
  input logic               targetAbortIn,
  input logic               sbeIn,
  input logic               mbeIn,
  input logic               parityErrIn,
  input logic               memEccIn,
  input logic               intParIn,
  input logic               intMaIn,
  input logic [MODE_W-1:0]  busMode,
  input logic               eccCorrEn,
  input logic [NUM_SRC-1:0] intMask,
  input logic [SEL_W-1:0]   regSel,
  input logic               regWrEn,
  input logic [NUM_SRC-1:0] regWrData,
  input logic [NUM_SRC-1:0] statusQ,
  input logic [NUM_SRC-1:0] intStatQ,
  input logic               irq,
  input logic               abortReq
);
  p_ma_status_r1: assert property (@(posedge clk) disable iff (!rstN)
    masterAbortIn |=> statusQ[IDX_MA]);

  p_mask_blocks_r2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((intStatQ & ~$past(intStatQ) & $past(intMask)) == '0));

  p_irq_reg_r3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irq == |($past(intStatQ) & ~$past(intMask))));

  p_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regSel == SEL_STATUS) |=> ((statusQ & $past(statusQ)) == $past(statusQ)));

  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rstN)
    (intMaIn && regWrEn && regSel == SEL_STATUS && regWrData[IDX_IMA]) |=> statusQ[IDX_IMA]);

  p_abort_r6: assert property (@(posedge clk) disable iff (!rstN)
    (masterAbortIn || targetAbortIn || memEccIn || intParIn || intMaIn) |=> abortReq);

  p_corrected_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busMode == MODE_ECC && eccCorrEn && sbeIn && !mbeIn && !parityErrIn && !masterAbortIn &&
     !targetAbortIn && !memEccIn && !intParIn && !intMaIn) |=> !abortReq);
endmodule

bind bridge_err_ctrl berr_checker u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .masterAbortIn(masterAbortIn),
  .targetAbortIn(targetAbortIn),
  .sbeIn        (sbeIn),
  .mbeIn        (mbeIn),
  .parityErrIn  (parityErrIn),
  .memEccIn     (memEccIn),
  .intParIn     (intParIn),
  .intMaIn      (intMaIn),
  .busMode      (busMode),
  .eccCorrEn    (eccCorrEn),
  .intMask      (intMask),
  .regSel       (regSel),
  .regWrEn      (regWrEn),
  .regWrData    (regWrData),
  .statusQ      (statusQ),
  .intStatQ     (intStatQ),
  .irq          (irq),
  .abortReq     (abortReq)
);

// File: tb/tb_bridge_err_ctrl.sv
`timescale 1ns/1ps
module tb_bridge_err_ctrl;
  import berr_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic masterAbortIn, targetAbortIn, parityErrIn, sbeIn, mbeIn;
  logic memEccIn, intParIn, intMaIn;
  logic [MODE_W-1:0]  busMode;
  logic               eccCorrEn;
  logic [NUM_SRC-1:0] intMask;
  logic [SEL_W-1:0]   regSel;
  logic               regWrEn;
  logic [NUM_SRC-1:0] regWrData;
  logic [NUM_SRC-1:0] regRdData;
  logic irq, abortReq;

  int total = 0;
  int bad = 0;

  logic [NUM_SRC-1:0] expStat = '0;
  logic [NUM_SRC-1:0] expInt  = '0;
  logic expIrq = 1'b0;
  logic expAbort = 1'b0;

  always #2.5 clk = ~clk;

  bridge_err_ctrl dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference classification: returns {fatal, setVec}
  function automatic logic [NUM_SRC:0] refEvents();
    logic [NUM_SRC-1:0] v = '0;
    logic ecc = (busMode == 2'd3);
    v[0] = masterAbortIn;
    v[1] = targetAbortIn;
    v[2] = ecc ? (mbeIn | (sbeIn & ~eccCorrEn)) : parityErrIn;
    v[3] = ecc & sbeIn & eccCorrEn;
    v[4] = memEccIn;
    v[5] = intParIn;
    v[6] = intMaIn;
    return {|(v & 7'b1110111), v};
  endfunction

  task automatic modelUpdate();
    logic [NUM_SRC:0] e = refEvents();
    logic [NUM_SRC-1:0] cs = (regWrEn && regSel == 1'b0) ? regWrData : '0;
    logic [NUM_SRC-1:0] ci = (regWrEn && regSel == 1'b1) ? regWrData : '0;
    expIrq   = |(expInt & ~intMask);
    expAbort = e[NUM_SRC];
    expStat  = (expStat & ~cs) | e[NUM_SRC-1:0];
    expInt   = (expInt & ~ci) | (e[NUM_SRC-1:0] & ~intMask);
  endtask

  task automatic clearPulses();
    {masterAbortIn, targetAbortIn, parityErrIn, sbeIn, mbeIn, memEccIn, intParIn, intMaIn} = '0;
    regWrEn = 1'b0;
    regWrData = '0;
  endtask

  // inputs are set at the negedge before the call
  task automatic tick();
    @(posedge clk);
    modelUpdate();
    #1;
    check(regSel ? "R2 intstat" : "R1 status", 32'(regRdData), 32'(regSel ? expInt : expStat));
    check("R3 irq", 32'(irq), 32'(expIrq));
    check("R6 abort", 32'(abortReq), 32'(expAbort));
    @(negedge clk);
    clearPulses();
  endtask

  task automatic clearAll();
    regSel = 1'b0; regWrEn = 1'b1; regWrData = '1; tick();
    regSel = 1'b1; regWrEn = 1'b1; regWrData = '1; tick();
    tick();
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    clearPulses();
    busMode = 2'd0; eccCorrEn = 1'b1; intMask = '0; regSel = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 status", 32'(regRdData), 0);
    check("R11 irq", 32'(irq), 0);
    check("R11 abort", 32'(abortReq), 0);
    regSel = 1'b1; #1;
    check("R11 intstat", 32'(regRdData), 0);
    regSel = 1'b0;

    // R1/R6/R3 master abort unmasked
    masterAbortIn = 1'b1; tick();
    check("R1 ma bit", 32'(regRdData), 32'h01);
    check("R6 abort after ma", 32'(abortReq), 1);
    tick();
    check("R3 irq rises", 32'(irq), 1);
    check("R6 abort single", 32'(abortReq), 0);
    // R12 read select
    regSel = 1'b1; #1;
    check("R12 read intstat", 32'(regRdData), 32'h01);
    // R4 clear intstat, R3 falls one cycle later
    regWrEn = 1'b1; regWrData = 7'h01; tick();
    check("R4 intstat cleared", 32'(regRdData), 0);
    check("R3 irq still high", 32'(irq), 1);
    tick();
    check("R3 irq fell", 32'(irq), 0);
    regSel = 1'b0; #1;
    check("R4 status untouched", 32'(regRdData), 32'h01);

    // R2 masked source
    intMask = 7'h02; targetAbortIn = 1'b1; tick();
    regSel = 1'b1; #1;
    check("R2 masked not set", 32'(regRdData), 0);
    regSel = 1'b0; #1;
    check("R2 status still set", 32'(regRdData), 32'h03);
    intMask = '0;

    // R5 set beats clear
    clearAll();
    intMaIn = 1'b1; regWrEn = 1'b1; regWrData = 7'h40; regSel = 1'b0; tick();
    check("R5 set wins", 32'(regRdData), 32'h40);

    // R7 parity modes
    for (int m = 0; m < 3; m++) begin
      clearAll();
      busMode = 2'(m);
      sbeIn = 1'b1; mbeIn = 1'b1; tick();
      check("R7 ecc ignored", 32'(regRdData), 0);
      check("R7 no abort", 32'(abortReq), 0);
      parityErrIn = 1'b1; tick();
      check("R7 parity unc", 32'(regRdData), 32'h04);
    end

    // R8 ECC mode
    clearAll();
    busMode = 2'd3;
    parityErrIn = 1'b1; tick();
    check("R8 parity ignored", 32'(regRdData), 0);
    mbeIn = 1'b1; tick();
    check("R8 mbe unc", 32'(regRdData), 32'h04);
    check("R8 abort", 32'(abortReq), 1);

    // R9 single-bit correction
    clearAll();
    eccCorrEn = 1'b1; sbeIn = 1'b1; tick();
    check("R9 corrected bit", 32'(regRdData), 32'h08);
    check("R9 no abort", 32'(abortReq), 0);
    tick();
    check("R9 corrected irq", 32'(irq), 1);
    clearAll();
    eccCorrEn = 1'b0; sbeIn = 1'b1; tick();
    check("R9 uncorrected bit", 32'(regRdData), 32'h04);
    check("R9 abort", 32'(abortReq), 1);

    // R10 internal sources
    clearAll();
    memEccIn = 1'b1; tick();
    check("R10 mem ecc", 32'(regRdData), 32'h10);
    check("R10 abort mem", 32'(abortReq), 1);
    intParIn = 1'b1; tick();
    check("R10 byte parity", 32'(regRdData), 32'h30);
    intMaIn = 1'b1; tick();
    check("R10 int ma", 32'(regRdData), 32'h70);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      masterAbortIn = ($urandom % 10) == 0;
      targetAbortIn = ($urandom % 10) == 0;
      parityErrIn   = ($urandom % 10) == 0;
      sbeIn         = ($urandom % 8) == 0;
      mbeIn         = ($urandom % 12) == 0;
      memEccIn      = ($urandom % 14) == 0;
      intParIn      = ($urandom % 14) == 0;
      intMaIn       = ($urandom % 14) == 0;
      busMode       = 2'($urandom);
      if (($urandom % 16) == 0) eccCorrEn = 1'($urandom);
      if (($urandom % 20) == 0) intMask = 7'($urandom);
      regSel = 1'($urandom);
      regWrEn = ($urandom % 4) == 0;
      regWrData = 7'($urandom);
      tick();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule